// File: doc/BRIEF.md
# Control Sub-Packet Command Interpreter

This block runs the commands carried in the payload of a control-channel packet. The payload arrives as a stream of 32-bit words and holds zero or more sub-packets. Each sub-packet starts on a word boundary. Its first word carries an opcode and a byte length, and any further argument words follow it. The interpreter walks these sub-packets one after another. It drives a register-file port with one-cycle read latency, and it emits reply words for the commands that need an answer. It stops when the payload byte count given at packet start is used up.

The queue logic upstream raises `pkt_start` only after the packet's timestamp condition is met at the head of the queue. The interpreter takes one word per handshake and lowers `word_ready` while it reads a register, writes a register or waits out a delay. It supports these commands:

- ping echo;
- register write;
- masked read-modify-write;
- register read with reply;
- tick delay.

Every other opcode is skipped using its length field. This includes reply opcodes, serial-bus opcodes and unknown values.

Top module: `ccp_cmd_interp`

## Requirements
- R1: With the block idle, a `pkt_start` pulse with nonzero `pay_len` (payload bytes) starts parsing, and `word_ready` rises on the next cycle. A zero `pay_len` starts nothing. A `pkt_start` that arrives while a packet is still in progress is ignored and does not change the remaining byte count.
- R2: A sub-packet's first word holds the opcode in bits [31:24] and the length in bits [23:16]. The sub-packet occupies ceil((length+2)/4) words, and the next sub-packet follows at once. Opcodes other than 0x00, 0x02, 0x03, 0x04 and 0x06 are consumed for their full word count and have no effect. This covers the reply codes 0x01 and 0x05, the serial-bus codes 0x10 to 0x15, and unknown values.
- R3: The block accepts exactly ceil(`pay_len`/4) words and then holds `word_ready` low until the next start. A sub-packet cut short by the end of the payload performs no action.
- R4: Ping (0x00, length 2) produces one reply word {0x01, 0x02, header[15:0]}. The reply copies the request ID from bits [15:10] and the ping value from bits [9:0]. It is valid in the cycle after the header is accepted.
- R5: Write (0x02, length 6) takes the register number from header bits [9:0] and the value from the next word. It raises `reg_we` for one cycle, in the cycle after the value word is accepted.
- R6: Masked write (0x03, length 10) takes the register number from header bits [9:0], then a value word, then a mask word. It reads the register and writes (old AND NOT mask) OR (value AND mask). The write is on the port two cycles after the mask word is accepted, and `reg_we` and `reg_re` are never high together.
- R7: Read (0x04, length 2) takes the request ID from header bits [15:10] and the register number from bits [9:0]. It raises `reg_re` for exactly one cycle, in the cycle after the header is accepted, and samples `reg_rdata` one cycle later. It then emits {0x05, 0x06, ID, register number} and the register value in two consecutive cycles. `word_ready` is low while `reg_re` is high.
- R8: Delay (0x06, length 2) holds `word_ready` low for exactly header[15:0] cycles after the header is accepted. A count of zero causes no stall.
- R9: An opcode from 0x00, 0x02, 0x03, 0x04 or 0x06 whose length differs from the one given above is skipped by its length, with no register access and no reply.
- R10: While reset is asserted, `word_ready`, `reg_we`, `reg_re` and `rpl_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | Start pulse for a control packet whose timestamp condition has been met |
| pay_len | input | 9 | Payload length in bytes, sampled with `pkt_start` |
| word_valid | input | 1 | Payload word valid |
| word_data | input | 32 | Payload word |
| word_ready | output | 1 | Interpreter accepts a word this cycle |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe; data is due one cycle later |
| reg_addr | output | 10 | Register number |
| reg_wdata | output | 32 | Register write value |
| reg_rdata | input | 32 | Register read data |
| rpl_valid | output | 1 | Reply word valid |
| rpl_data | output | 32 | Reply word |

## Verification
Every result has a fixed due cycle, counted from the clock edge that accepts the word that triggers it:

- a ping reply and a plain write are due in the cycle right after that edge;
- a read reply comes one cycle later, with its value word on the cycle after that;
- a masked write reaches the port two cycles after its mask word is accepted;
- a delay of N ticks puts N+1 edges between accepting the delay header and accepting the next header.

The bench numbers clock edges. It records the edge at which each handshake happens and the cycle in which each reply word and write strobe appears, and it compares those offsets, not only the values, against the figures above.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int WORD_W    = 32;
  localparam int REGNUM_W  = 10;
  localparam int RID_W     = 6;
  localparam logic [7:0] OP_PING     = 8'h00;
  localparam logic [7:0] OP_PING_RPL = 8'h01;
  localparam logic [7:0] OP_WR       = 8'h02;
  localparam logic [7:0] OP_MWR      = 8'h03;
  localparam logic [7:0] OP_RD       = 8'h04;
  localparam logic [7:0] OP_RD_RPL   = 8'h05;
  localparam logic [7:0] OP_DLY      = 8'h06;

  typedef enum logic [2:0] {
    ACT_SKIP, ACT_PING, ACT_WR, ACT_MWR, ACT_RD, ACT_DLY
  } act_e;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_ARG, S_RD, S_RDOUT, S_RMW_RD, S_RMW_WR, S_DLY
  } st_e;
endpackage

// File: rtl/ccp_subpkt_decode.sv
module ccp_subpkt_decode
  import ccp_pkg::*;
#(
  parameter int XW = 7
) (
  input  logic [WORD_W-1:0] hdr,
  output act_e              act,
  output logic [XW-1:0]     extra
);
  logic [7:0] op;
  logic [7:0] len;
  logic [8:0] len_p1;

  assign op     = hdr[31:24];
  assign len    = hdr[23:16];
  assign len_p1 = {1'b0, len} + 9'd1;
  // words after the header: ceil((len+2)/4) - 1
  assign extra  = XW'(len_p1 >> 2);

  always_comb begin
    act = ACT_SKIP;
    case (op)
      OP_PING: if (len == 8'd2)  act = ACT_PING;
      OP_WR:   if (len == 8'd6)  act = ACT_WR;
      OP_MWR:  if (len == 8'd10) act = ACT_MWR;
      OP_RD:   if (len == 8'd2)  act = ACT_RD;
      OP_DLY:  if (len == 8'd2)  act = ACT_DLY;
      default: act = ACT_SKIP;
    endcase
  end
endmodule

// File: rtl/ccp_delay_timer.sv
module ccp_delay_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] ticks,
  output logic          last
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = ticks;
    else if (cnt_q != '0)  cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == TW'(1));
endmodule

// File: rtl/ccp_seq.sv
module ccp_seq
  import ccp_pkg::*;
#(
  parameter int LW = 9,
  parameter int XW = 7,
  parameter int TW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pkt_start,
  input  logic [LW-1:0]       pay_len,
  input  logic                word_valid,
  input  logic [WORD_W-1:0]   word_data,
  output logic                word_ready,
  input  act_e                act,
  input  logic [XW-1:0]       extra,
  output logic                dly_load,
  input  logic                dly_last,
  output logic                reg_we,
  output logic                reg_re,
  output logic [REGNUM_W-1:0] reg_addr,
  output logic [WORD_W-1:0]   reg_wdata,
  input  logic [WORD_W-1:0]   reg_rdata,
  output logic                rpl_valid,
  output logic [WORD_W-1:0]   rpl_data
);
  localparam int BPW = WORD_W / 8;

  st_e                 st_q, st_d;
  act_e                act_q, act_d;
  logic [LW-1:0]       rem_q, rem_d, rem_after;
  logic [XW-1:0]       cnt_q, cnt_d;
  logic [REGNUM_W-1:0] addr_q, addr_d;
  logic [RID_W-1:0]    rid_q, rid_d;
  logic [WORD_W-1:0]   val_q, val_d, mask_q, mask_d;
  logic [WORD_W-1:0]   wdat_q, wdat_d, rdat_q, rdat_d;
  logic                we_q, we_d, rv_q, rv_d;
  logic                take;
  st_e                 end_take, end_hold;

  assign word_ready = (st_q == S_HDR) || (st_q == S_ARG);
  assign take       = word_valid && word_ready;
  assign rem_after  = (rem_q > LW'(BPW)) ? rem_q - LW'(BPW) : '0;
  assign end_take   = (rem_after == '0) ? S_IDLE : S_HDR;
  assign end_hold   = (rem_q == '0) ? S_IDLE : S_HDR;

  always_comb begin
    st_d = st_q;   act_d = act_q;   rem_d = rem_q;   cnt_d = cnt_q;
    addr_d = addr_q; rid_d = rid_q; val_d = val_q;   mask_d = mask_q;
    wdat_d = wdat_q; rdat_d = rdat_q;
    we_d = 1'b0;   rv_d = 1'b0;     dly_load = 1'b0;
    if (take) rem_d = rem_after;
    case (st_q)
      S_IDLE: begin
        if (pkt_start && (pay_len != '0)) begin
          rem_d = pay_len;
          st_d  = S_HDR;
        end
      end
      S_HDR: begin
        if (take) begin
          act_d  = act;
          addr_d = word_data[REGNUM_W-1:0];
          rid_d  = word_data[15:10];
          if (extra != '0) begin
            cnt_d = extra;
            st_d  = (rem_after == '0) ? S_IDLE : S_ARG;
          end else begin
            case (act)
              ACT_PING: begin
                rv_d   = 1'b1;
                rdat_d = {OP_PING_RPL, 8'd2, word_data[15:0]};
                st_d   = end_take;
              end
              ACT_RD:  st_d = S_RD;
              ACT_DLY: begin
                if (word_data[TW-1:0] != '0) begin
                  dly_load = 1'b1;
                  st_d     = S_DLY;
                end else st_d = end_take;
              end
              default: st_d = end_take;
            endcase
          end
        end
      end
      S_ARG: begin
        if (take) begin
          cnt_d = cnt_q - XW'(1);
          if (cnt_q == XW'(1)) begin
            if (act_q == ACT_WR) begin
              we_d   = 1'b1;
              wdat_d = word_data;
              st_d   = end_take;
            end else if (act_q == ACT_MWR) begin
              mask_d = word_data;
              st_d   = S_RMW_RD;
            end else st_d = end_take;
          end else begin
            val_d = word_data;
            if (rem_after == '0) st_d = S_IDLE;
          end
        end
      end
      S_RD: begin
        rv_d   = 1'b1;
        rdat_d = {OP_RD_RPL, 8'd6, rid_q, addr_q};
        st_d   = S_RDOUT;
      end
      S_RDOUT: begin
        rv_d   = 1'b1;
        rdat_d = reg_rdata;
        st_d   = end_hold;
      end
      S_RMW_RD: st_d = S_RMW_WR;
      S_RMW_WR: begin
        we_d   = 1'b1;
        wdat_d = (reg_rdata & ~mask_q) | (val_q & mask_q);
        st_d   = end_hold;
      end
      S_DLY:   if (dly_last) st_d = end_hold;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  act_q <= ACT_SKIP; rem_q <= '0;  cnt_q <= '0;
      addr_q <= '0;    rid_q <= '0;       val_q <= '0;  mask_q <= '0;
      wdat_q <= '0;    rdat_q <= '0;      we_q <= 1'b0; rv_q <= 1'b0;
    end else begin
      st_q <= st_d;    act_q <= act_d;    rem_q <= rem_d; cnt_q <= cnt_d;
      addr_q <= addr_d; rid_q <= rid_d;   val_q <= val_d; mask_q <= mask_d;
      wdat_q <= wdat_d; rdat_q <= rdat_d; we_q <= we_d;   rv_q <= rv_d;
    end
  end

  assign reg_re    = (st_q == S_RD) || (st_q == S_RMW_RD);
  assign reg_addr  = addr_q;
  assign reg_we    = we_q;
  assign reg_wdata = wdat_q;
  assign rpl_valid = rv_q;
  assign rpl_data  = rdat_q;
endmodule

// File: rtl/ccp_cmd_interp.sv
module ccp_cmd_interp
  import ccp_pkg::*;
#(
  parameter int LEN_W  = 9,
  parameter int TICK_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pkt_start,
  input  logic [LEN_W-1:0]    pay_len,
  input  logic                word_valid,
  input  logic [WORD_W-1:0]   word_data,
  output logic                word_ready,
  output logic                reg_we,
  output logic                reg_re,
  output logic [REGNUM_W-1:0] reg_addr,
  output logic [WORD_W-1:0]   reg_wdata,
  input  logic [WORD_W-1:0]   reg_rdata,
  output logic                rpl_valid,
  output logic [WORD_W-1:0]   rpl_data
);
  localparam int XW = 7;

  act_e            dec_act;
  logic [XW-1:0]   dec_extra;
  logic            dly_load, dly_last;

  ccp_subpkt_decode #(.XW(XW)) u_dec (
    .hdr   (word_data),
    .act   (dec_act),
    .extra (dec_extra)
  );

  ccp_delay_timer #(.TW(TICK_W)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (dly_load),
    .ticks (word_data[TICK_W-1:0]),
    .last  (dly_last)
  );

  ccp_seq #(.LW(LEN_W), .XW(XW), .TW(TICK_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_start  (pkt_start),
    .pay_len    (pay_len),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_ready (word_ready),
    .act        (dec_act),
    .extra      (dec_extra),
    .dly_load   (dly_load),
    .dly_last   (dly_last),
    .reg_we     (reg_we),
    .reg_re     (reg_re),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .rpl_valid  (rpl_valid),
    .rpl_data   (rpl_data)
  );
endmodule

// File: rtl/ccp_cmd_interp_chk.sv
module ccp_cmd_interp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        word_ready,
  input logic        reg_we,
  input logic        reg_re,
  input logic        rpl_valid,
  input logic [31:0] rpl_data
);
  // R7
  rd_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);

  // R7
  rd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |-> !word_ready);

  // R7
  rd_reply_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rpl_valid) && rpl_data[31:24] == 8'h05) |=> rpl_valid);

  // R6
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));

  // R4
  ping_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rpl_valid) && rpl_data[31:24] == 8'h01) |-> rpl_data[23:16] == 8'd2);
endmodule

bind ccp_cmd_interp ccp_cmd_interp_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_ready (word_ready),
  .reg_we     (reg_we),
  .reg_re     (reg_re),
  .rpl_valid  (rpl_valid),
  .rpl_data   (rpl_data)
);

// File: tb/test_ccp_cmd_interp.sv
module test_ccp_cmd_interp;
  logic        clk, rst_n, pkt_start, word_valid, word_ready;
  logic [8:0]  pay_len;
  logic [31:0] word_data, reg_wdata, reg_rdata, rpl_data;
  logic        reg_we, reg_re, rpl_valid;
  logic [9:0]  reg_addr;

  ccp_cmd_interp i_ccp_cmd_interp (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pay_len(pay_len),
    .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rpl_valid(rpl_valid), .rpl_data(rpl_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // register file model with one-cycle read latency
  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    if (reg_we) mem[reg_addr] <= reg_wdata;
    if (reg_re) reg_rdata <= mem[reg_addr];
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          n_chk = 0, n_fail = 0;
  int          hs_n = 0, rpl_n = 0, wr_n = 0, wr_cyc = 0;
  int          hs_log [0:255];
  logic [31:0] rpl_buf [0:255];
  int          rpl_cyc [0:255];
  logic [31:0] pw [0:7];

  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid && word_ready) begin hs_log[hs_n] = cyc + 1; hs_n++; end
      if (rpl_valid) begin rpl_buf[rpl_n] = rpl_data; rpl_cyc[rpl_n] = cyc; rpl_n++; end
      if (reg_we) begin wr_n++; wr_cyc = cyc; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pkt(input int n, input logic [8:0] plen);
    @(negedge clk);
    pkt_start = 1'b1; pay_len = plen;
    @(negedge clk);
    pkt_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      word_valid = 1'b1; word_data = pw[i];
      while (!word_ready) @(negedge clk);
      @(negedge clk);
    end
    word_valid = 1'b0;
  endtask

  // addr, init, value, mask, expected after masked write
  localparam logic [31:0] TV [0:3][0:4] = '{
    '{32'h005, 32'hFFFF0000, 32'h12345678, 32'h00FF00FF, 32'hFF340078},
    '{32'h3FF, 32'h00000000, 32'hFFFFFFFF, 32'h80000001, 32'h80000001},
    '{32'h000, 32'hA5A5A5A5, 32'h00000000, 32'hFFFFFFFF, 32'h00000000},
    '{32'h155, 32'hDEADBEEF, 32'h00000000, 32'h00000000, 32'hDEADBEEF}
  };

  bit done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int r0, w0, h0;
    rst_n = 1'b0; pkt_start = 1'b0; pay_len = '0; word_valid = 1'b0; word_data = '0;
    idle(3);
    // R10 reset state
    chk(!word_ready && !reg_we && !reg_re && !rpl_valid, "R10",
        {28'd0, word_ready, reg_we, reg_re, rpl_valid}, 32'd0);
    rst_n = 1'b1;
    idle(2);

    // table: write, masked write, read back
    for (int i = 0; i < 4; i++) begin
      logic [9:0] a;
      logic [5:0] rid;
      a = TV[i][0][9:0];
      rid = 6'(i + 1);
      w0 = wr_n;
      pw[0] = {8'h02, 8'd6, 6'd0, a}; pw[1] = TV[i][1];
      send_pkt(2, 9'd8); idle(3);
      // R5 write strobe one cycle after value word
      chk(wr_n == w0 + 1 && wr_cyc == hs_log[hs_n-1], "R5", 32'(wr_cyc), 32'(hs_log[hs_n-1]));
      chk(mem[a] == TV[i][1], "R5", mem[a], TV[i][1]);
      pw[0] = {8'h03, 8'd10, 6'd0, a}; pw[1] = TV[i][2]; pw[2] = TV[i][3];
      send_pkt(3, 9'd12); idle(5);
      // R6 merged write two cycles after mask word
      chk(wr_cyc == hs_log[hs_n-1] + 2, "R6", 32'(wr_cyc), 32'(hs_log[hs_n-1] + 2));
      chk(mem[a] == TV[i][4], "R6", mem[a], TV[i][4]);
      r0 = rpl_n;
      pw[0] = {8'h04, 8'd2, rid, a};
      send_pkt(1, 9'd4); idle(5);
      // R7 reply header, then value, in consecutive cycles
      chk(rpl_n == r0 + 2 && rpl_buf[r0] == {8'h05, 8'd6, rid, a}, "R7", rpl_buf[r0], {8'h05, 8'd6, rid, a});
      chk(rpl_cyc[r0] == hs_log[hs_n-1] + 1 && rpl_cyc[r0+1] == rpl_cyc[r0] + 1, "R7",
          32'(rpl_cyc[r0+1]), 32'(hs_log[hs_n-1] + 2));
      chk(rpl_buf[r0+1] == TV[i][4], "R7", rpl_buf[r0+1], TV[i][4]);
    end

    // R4 ping echo and timing
    r0 = rpl_n;
    pw[0] = {8'h00, 8'd2, 16'hABC5};
    send_pkt(1, 9'd4); idle(3);
    chk(rpl_n == r0 + 1 && rpl_buf[r0] == 32'h0102ABC5, "R4", rpl_buf[r0], 32'h0102ABC5);
    chk(rpl_cyc[r0] == hs_log[hs_n-1], "R4", 32'(rpl_cyc[r0]), 32'(hs_log[hs_n-1]));
    // R3 payload used up: no further words taken
    chk(!word_ready, "R3", {31'd0, word_ready}, 32'd0);

    // R2 skip serial-bus and unknown opcodes between pings
    r0 = rpl_n; w0 = wr_n;
    pw[0] = {8'h00, 8'd2, 16'h1111};
    pw[1] = {8'h10, 8'd3, 16'h0000}; pw[2] = {8'h00, 8'd2, 16'hFFFF};
    pw[3] = {8'h7E, 8'd5, 16'h0000}; pw[4] = {8'h02, 8'd6, 16'h0005};
    pw[5] = {8'h00, 8'd2, 16'h1234};
    send_pkt(6, 9'd24); idle(3);
    chk(rpl_n == r0 + 2 && wr_n == w0, "R2", 32'(rpl_n - r0), 32'd2);
    chk(rpl_buf[r0+1] == 32'h01021234, "R2", rpl_buf[r0+1], 32'h01021234);

    // R3 odd byte count rounds up to a second word
    r0 = rpl_n;
    pw[0] = {8'h00, 8'd2, 16'h0001}; pw[1] = {8'h00, 8'd2, 16'h0002};
    send_pkt(2, 9'd6); idle(3);
    chk(rpl_n == r0 + 2 && !word_ready, "R3", 32'(rpl_n - r0), 32'd2);

    // R1 zero payload length starts nothing
    @(negedge clk); pkt_start = 1'b1; pay_len = 9'd0;
    @(negedge clk); pkt_start = 1'b0;
    idle(2);
    chk(!word_ready, "R1", {31'd0, word_ready}, 32'd0);

    // R3 truncated masked write does nothing
    w0 = wr_n;
    pw[0] = {8'h03, 8'd10, 16'h0005}; pw[1] = 32'hFFFFFFFF;
    send_pkt(2, 9'd8); idle(5);
    chk(wr_n == w0 && !word_ready, "R3", 32'(wr_n - w0), 32'd0);

    // R9 write with a wrong length is skipped
    w0 = wr_n;
    pw[0] = {8'h02, 8'd2, 16'h0005};
    send_pkt(1, 9'd4); idle(4);
    chk(wr_n == w0, "R9", 32'(wr_n - w0), 32'd0);

    // R8 delay of 6 ticks, R1 start pulse during it ignored
    r0 = rpl_n;
    h0 = hs_n;
    pw[0] = {8'h06, 8'd2, 16'd6}; pw[1] = {8'h00, 8'd2, 16'h0003};
    fork
      send_pkt(2, 9'd8);
      begin
        idle(4);
        pkt_start = 1'b1; pay_len = 9'd100;
        @(negedge clk); pkt_start = 1'b0;
      end
    join
    idle(3);
    chk(hs_log[h0+1] - hs_log[h0] == 7, "R8", 32'(hs_log[h0+1] - hs_log[h0]), 32'd7);
    chk(rpl_n == r0 + 1 && !word_ready, "R1", {31'd0, word_ready}, 32'd0);

    // R8 zero delay causes no stall
    h0 = hs_n;
    pw[0] = {8'h06, 8'd2, 16'd0}; pw[1] = {8'h00, 8'd2, 16'h0004};
    send_pkt(2, 9'd8); idle(3);
    chk(hs_log[h0+1] - hs_log[h0] == 1, "R8", 32'(hs_log[h0+1] - hs_log[h0]), 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule